// File: doc/BRIEF.md
# Word-Interleaved Bank Address Router

This block sits between one memory request port and a group of equally sized memory banks. The number of banks is a power of two. Consecutive 32-bit words go to consecutive banks in rotation. A run of sequential accesses is therefore spread over every bank instead of hammering one.

For each request the router takes the bank number from the address bits just above the byte-in-word field. It then strips those bits out of the address, which gives each bank a dense local offset. The byte-in-word bits are kept. The request is presented to that one bank only. The write flag, size and write data are broadcast to all banks unchanged, and only the selected bank sees a valid.

The router records the bank of every accepted request in a small in-order queue. Each response is taken from the bank that holds the oldest outstanding request. When the queue is full, no further request is forwarded.

Top module: `wib_router`

## Requirements
- R1: For a valid request, exactly one bank valid is raised: bank number `(addr >> 2) & (NUM_BANKS-1)`, which is address bits [2 +: log2(NUM_BANKS)]. Every other bank valid stays low.
- R2: The bank address equals `((addr >> (log2(NUM_BANKS)+2)) << 2) | addr[1:0]`. The bits above the shifted field are zero.
- R3: The write flag, size and write data reach the banks unchanged.
- R4: In the same cycle, `up_ready` equals the selected bank's ready, gated only by the outstanding limit. A request is accepted when `up_valid` and `up_ready` are both high.
- R5: `up_rvalid` and `up_rdata` come from the bank of the oldest outstanding request. Response valids from any other bank, or while nothing is outstanding, are ignored.
- R6: At most `MAX_OUT` requests are outstanding. While the limit is reached, no bank valid is raised and `up_ready` is low.
- R7: After reset, nothing is outstanding, no bank valid is raised and `up_rvalid` is low.
- R8: Sequential word addresses 0, 4, 8, ... visit banks 0, 1, ..., NUM_BANKS-1 in rotation. Within each bank the offsets climb by 4 bytes per visit, starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted this cycle |
| up_addr | input | ADDR_W | Request byte address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | SIZE_W | Access size, passed through |
| up_wdata | input | DATA_W | Write data |
| up_rvalid | output | 1 | Response valid |
| up_rdata | output | DATA_W | Response data |
| bk_valid | output | NUM_BANKS | Per-bank request valid |
| bk_ready | input | NUM_BANKS | Per-bank ready |
| bk_addr | output | ADDR_W | Local bank offset, shared by all banks |
| bk_write | output | 1 | Write flag to banks |
| bk_size | output | SIZE_W | Size to banks |
| bk_wdata | output | DATA_W | Write data to banks |
| bk_rvalid | input | NUM_BANKS | Per-bank response valid |
| bk_rdata | input | NUM_BANKS*DATA_W | Per-bank response data, bank b at bits [b*DATA_W +: DATA_W] |

## Verification
The bound checker checks on every cycle that:
- at most one bank valid is raised, and it belongs to the addressed bank;
- an accepted request coincides with that bank's ready;
- the outstanding count never passes its limit and grows by one on an accept with no response;
- a full queue blocks forwarding;
- no response appears while nothing is outstanding.

Only the bench scenarios can show the rest:
- the exact offset arithmetic;
- the rotation and contiguity of a sequential sweep;
- that data written through one bank comes back from the right bank in order;
- that stray response valids are ignored;
- that ready is withheld while a bank stalls or the queue is full.

// File: rtl/wib_router.sv
module wib_router #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 3,
  parameter int MAX_OUT   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        up_valid,
  output logic                        up_ready,
  input  logic [ADDR_W-1:0]           up_addr,
  input  logic                        up_write,
  input  logic [SIZE_W-1:0]           up_size,
  input  logic [DATA_W-1:0]           up_wdata,
  output logic                        up_rvalid,
  output logic [DATA_W-1:0]           up_rdata,
  output logic [NUM_BANKS-1:0]        bk_valid,
  input  logic [NUM_BANKS-1:0]        bk_ready,
  output logic [ADDR_W-1:0]           bk_addr,
  output logic                        bk_write,
  output logic [SIZE_W-1:0]           bk_size,
  output logic [DATA_W-1:0]           bk_wdata,
  input  logic [NUM_BANKS-1:0]        bk_rvalid,
  input  logic [NUM_BANKS*DATA_W-1:0] bk_rdata
);
  localparam int SEL_W = $clog2(NUM_BANKS);
  localparam int PTR_W = $clog2(MAX_OUT);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic [SEL_W-1:0] sel;
  logic [SEL_W-1:0] q [MAX_OUT];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] head;
  logic             full, push, pop;

  assign sel      = up_addr[2 +: SEL_W];
  assign full     = (cnt == CNT_W'(MAX_OUT));
  assign bk_addr  = {{SEL_W{1'b0}}, up_addr[ADDR_W-1:SEL_W+2], up_addr[1:0]};
  assign bk_write = up_write;
  assign bk_size  = up_size;
  assign bk_wdata = up_wdata;
  assign bk_valid = {NUM_BANKS{up_valid & ~full}} & (NUM_BANKS'(1) << sel);
  assign up_ready = bk_ready[sel] & ~full;
  assign push     = up_valid & up_ready;

  assign head      = q[rd_ptr];
  assign up_rvalid = (cnt != '0) & bk_rvalid[head];
  assign up_rdata  = bk_rdata[head*DATA_W +: DATA_W];
  assign pop       = up_rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) q[wr_ptr] <= sel;
  end
endmodule

// File: rtl/wib_router_chk.sv
module wib_router_chk #(
  parameter int NUM_BANKS = 4,
  parameter int MAX_OUT   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         up_valid,
  input logic                         up_ready,
  input logic                         up_rvalid,
  input logic [$clog2(NUM_BANKS)-1:0] sel_bits,
  input logic [NUM_BANKS-1:0]         bk_valid,
  input logic [NUM_BANKS-1:0]         bk_ready,
  input logic [$clog2(MAX_OUT+1)-1:0] cnt
);
  a_r1_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bk_valid));
  a_r1_right_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_valid != '0) |-> bk_valid[sel_bits]);
  a_r4_ready_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |-> (bk_ready[sel_bits] && bk_valid[sel_bits]));
  a_r6_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(MAX_OUT+1))'(MAX_OUT));
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == ($clog2(MAX_OUT+1))'(MAX_OUT)) |-> (bk_valid == '0 && !up_ready));
  a_r5_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !up_rvalid);
  a_r5_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && !up_rvalid) |=> (cnt == $past(cnt) + 1'b1));
endmodule

bind wib_router wib_router_chk #(.NUM_BANKS(NUM_BANKS), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
  .up_rvalid(up_rvalid), .sel_bits(up_addr[2 +: SEL_W]), .bk_valid(bk_valid),
  .bk_ready(bk_ready), .cnt(cnt)
);

// File: tb/wib_router_tb.sv
module wib_router_tb;
  localparam int NB = 4, AW = 32, DW = 32, SW = 3, MO = 4;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic          up_valid = 0, up_write = 0;
  logic [AW-1:0] up_addr = 0;
  logic [SW-1:0] up_size = 0;
  logic [DW-1:0] up_wdata = 0;
  logic          up_ready, up_rvalid;
  logic [DW-1:0] up_rdata;
  logic [NB-1:0] bk_valid, bk_ready, bk_rvalid;
  logic [AW-1:0] bk_addr;
  logic          bk_write;
  logic [SW-1:0] bk_size;
  logic [DW-1:0] bk_wdata;
  logic [NB*DW-1:0] bk_rdata;

  logic [NB-1:0] stall = 0, stray = 0;
  logic gate = 0;
  logic rv_on = 0;
  logic [1:0] rv_bank = 0;
  logic [DW-1:0] rv_data = 0;

  wib_router #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW), .MAX_OUT(MO)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_write(up_write), .up_size(up_size), .up_wdata(up_wdata), .up_rvalid(up_rvalid),
    .up_rdata(up_rdata), .bk_valid(bk_valid), .bk_ready(bk_ready), .bk_addr(bk_addr),
    .bk_write(bk_write), .bk_size(bk_size), .bk_wdata(bk_wdata), .bk_rvalid(bk_rvalid),
    .bk_rdata(bk_rdata));

  int n_chk = 0, n_fail = 0, out_cnt = 0;
  logic [DW-1:0] bmem [NB][16];
  logic [DW-1:0] ref_mem [64];
  bit        exp_wr [$];
  bit [31:0] exp_dat [$];
  int        rsp_b [$];
  bit [31:0] rsp_d [$];
  int        obs_bank [$];
  bit [31:0] obs_off [$];

  assign bk_ready  = ~stall;
  assign bk_rvalid = (rv_on ? (NB'(1) << rv_bank) : '0) | stray;
  always_comb
    for (int b = 0; b < NB; b++)
      bk_rdata[b*DW +: DW] = (rv_on && rv_bank == 2'(b)) ? rv_data : (32'hDEAD0000 | b);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bank models: one-cycle response, in acceptance order, holdable by gate
  always @(posedge clk) begin
    if (!rst_n) begin
      rv_on <= 0;
    end else begin
      if (rv_on) begin
        void'(rsp_b.pop_front());
        void'(rsp_d.pop_front());
      end
      for (int b = 0; b < NB; b++)
        if (bk_valid[b] && bk_ready[b]) begin
          if (bk_write) bmem[b][bk_addr[5:2]] = bk_wdata;
          rsp_b.push_back(b);
          rsp_d.push_back(bk_write ? 32'h0 : bmem[b][bk_addr[5:2]]);
        end
      if (!gate && rsp_b.size() > 0) begin
        rv_on   <= 1;
        rv_bank <= 2'(rsp_b[0]);
        rv_data <= rsp_d[0];
      end else rv_on <= 0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      int eb;
      bit efull;
      logic [AW-1:0] eoff;
      eb    = int'((up_addr >> 2) % NB);
      efull = (out_cnt == MO);
      eoff  = ((up_addr / 16) * 4) + (up_addr % 4);
      if (up_valid) begin
        if (efull) chk(bk_valid == 0, "R6 full blocks bank valid", 64'(bk_valid), 0);
        else chk(bk_valid == (NB'(1) << eb), "R1 bank select", 64'(bk_valid), 64'(NB'(1) << eb));
        chk(bk_addr == eoff, "R2 local offset", bk_addr, eoff);
        chk(bk_write == up_write && bk_size == up_size && bk_wdata == up_wdata,
            "R3 pass-through", {bk_write, bk_size, bk_wdata}, {up_write, up_size, up_wdata});
        chk(up_ready == (!stall[eb] && !efull), "R4 ready follows bank", 64'(up_ready),
            64'(!stall[eb] && !efull));
      end else chk(bk_valid == 0, "R1 no valid when idle", 64'(bk_valid), 0);
      if (out_cnt == 0) chk(!up_rvalid, "R5 no response when idle", 64'(up_rvalid), 0);
      if (up_rvalid) begin
        if (exp_wr.size() == 0) chk(0, "R5 unexpected response", 1, 0);
        else begin
          bit w;
          bit [31:0] d;
          w = exp_wr.pop_front();
          d = exp_dat.pop_front();
          if (!w) chk(up_rdata == d, "R5 read data", up_rdata, d);
        end
      end
      if (up_valid && up_ready) begin
        int ob = 0;
        for (int b = 0; b < NB; b++) if (bk_valid[b]) ob = b;
        obs_bank.push_back(ob);
        obs_off.push_back(bk_addr);
      end
      out_cnt = out_cnt + int'(up_valid && up_ready) - int'(up_rvalid);
    end
  end

  task automatic issue(input [31:0] a, input bit w, input [2:0] sz, input [31:0] d);
    @(posedge clk); #1;
    up_valid = 1; up_addr = a; up_write = w; up_size = sz; up_wdata = d;
    forever begin
      @(negedge clk);
      if (up_ready) break;
    end
    exp_wr.push_back(w);
    exp_dat.push_back(ref_mem[a[7:2]]);
    if (w) ref_mem[a[7:2]] = d;
    @(posedge clk); #1;
    up_valid = 0;
  endtask

  task automatic drain();
    while (out_cnt != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int i = 0; i < 16; i++) bmem[b][i] = 0;
    for (int i = 0; i < 64; i++) ref_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(bk_valid == 0 && !up_rvalid, "R7 reset state", {bk_valid, up_rvalid}, 0);

    // R8: sequential sweep rotates banks, offsets contiguous per bank
    obs_bank.delete(); obs_off.delete();
    for (int i = 0; i < 16; i++) issue(32'(i * 4), 1, 3'd2, 32'hA000 + i);
    drain();
    for (int i = 0; i < 16; i++) begin
      chk(obs_bank[i] == i % NB, "R8 bank rotation", 64'(obs_bank[i]), 64'(i % NB));
      chk(obs_off[i] == 32'((i / NB) * 4), "R8 contiguous offset", obs_off[i], 64'((i / NB) * 4));
    end

    // R5: read back in reverse order
    for (int i = 15; i >= 0; i--) issue(32'(i * 4), 0, 3'd2, 0);
    drain();

    // R2/R3: unaligned byte addresses, varied sizes
    issue(32'h25, 1, 3'd0, 32'h11223344);
    issue(32'h3A, 1, 3'd1, 32'h55667788);
    issue(32'hF7, 1, 3'd2, 32'h99AABBCC);
    issue(32'h25, 0, 3'd0, 0);
    issue(32'h3A, 0, 3'd1, 0);
    issue(32'hF7, 0, 3'd2, 0);
    drain();

    // R4: stalled bank withholds ready
    @(posedge clk); #1 stall = 4'b0010;
    fork
      issue(32'h44, 1, 3'd2, 32'hC0FFEE01);
      begin repeat (6) @(posedge clk); #1 stall = 0; end
    join
    issue(32'h44, 0, 3'd2, 0);
    drain();

    // R6: queue full blocks further requests
    @(posedge clk); #1 gate = 1;
    for (int i = 0; i < MO; i++) issue(32'(i * 4 + 64), 0, 3'd2, 0);
    fork
      issue(32'h80, 0, 3'd2, 0);
      begin repeat (6) @(posedge clk); #1 gate = 0; end
    join
    drain();

    // R5: stray response valids ignored while idle
    @(posedge clk); #1 stray = 4'b0100;
    repeat (2) @(negedge clk);
    chk(!up_rvalid, "R5 stray valid ignored", 64'(up_rvalid), 0);
    @(posedge clk); #1 stray = 0;

    // mixed strides
    for (int i = 0; i < 12; i++) issue(32'((i * 28) % 256), i % 3 == 0, 3'd2, 32'hB000 + i);
    for (int i = 0; i < 12; i++) issue(32'((i * 28) % 256), 0, 3'd2, 0);
    drain();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule